// File: doc/BRIEF.md
# NAND Sector Single-Bit Hamming ECC Engine

This block protects one NAND sector with a single-error-correcting line-parity code. A frame begins with a one-cycle `start` pulse. The engine then accepts the sector's bytes in storage order through a valid/ready byte stream. While the bytes arrive it folds each one into two 12-bit parity halves. One cycle after the last byte is accepted, `ecc_valid` pulses and `ecc_code` carries the three inverted code bytes that the host writes to spare storage.

When `check_mode` is high at `start`, the engine also latches the code that was previously stored for the sector (`stored_ecc`). After the fresh code has been produced, it compares the two codes. One cycle after `ecc_valid`, `result_valid` pulses and `result_status` gives one of four verdicts:
- the sector is clean;
- a single data bit is wrong, with its byte offset and a flip mask;
- only the stored code is damaged;
- the sector cannot be repaired.

The host applies any bit flip to its own buffer.

Top module: `nand_hecc_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ready`, `ecc_valid` and `result_valid` are all 0.
- R2: `start` clears the parity and byte count and raises `in_ready` on the next cycle. A byte presented in the same cycle as `start` is discarded. A `start` during a frame abandons that frame and begins a new one.
- R3: Bytes presented while `in_ready` is 0 have no effect on the code of the next frame.
- R4: `ecc_valid` is high for exactly one cycle, in the cycle after the 512th accepted byte of a frame. `in_ready` is 0 in that same cycle.
- R5: For the data bit at 12-bit position P = {byte offset[8:0], bit index[2:0]}:
  - high parity bit k is the XOR of all data bits whose P has bit k set;
  - low parity bit k is the XOR of all data bits whose P has bit k clear.
- R6: `ecc_code[11:0]` is the inverted low half and `ecc_code[23:12]` is the inverted high half. Byte 0 of storage is bits 7:0. A sector of all 0xFF yields 0xFFFFFF.
- R7: `result_valid` pulses only in the cycle after `ecc_valid`, and only when `check_mode` was 1 at that frame's `start`.
- R8: D denotes `stored_ecc` XOR `ecc_code`. When D is 0, `result_status` is 0 (clean) and `err_mask` is 0.
- R9: When D[11:0] XOR D[23:12] equals 0xFFF and D[23:15] is below the sector size, `result_status` is 1 (data fix). `err_byte` is D[23:15] and `err_mask` is 1 shifted left by D[14:12].
- R10: When D has exactly one bit set, `result_status` is 2 (code-only error) and `err_mask` is 0.
- R11: Any other non-zero D gives `result_status` 3 (uncorrectable) and `err_mask` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sector frame |
| check_mode | input | 1 | Sampled at start: also compare against stored code |
| stored_ecc | input | 24 | Sampled at start: code read back from spare storage |
| in_valid | input | 1 | A data byte is presented |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Frame open; a presented byte is accepted |
| ecc_valid | output | 1 | One-cycle strobe: ecc_code is the frame's code |
| ecc_code | output | 24 | Inverted packed parity, byte 0 in bits 7:0 |
| result_valid | output | 1 | One-cycle strobe: check verdict is valid |
| result_status | output | 2 | 0 clean, 1 data fix, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte offset to repair (data fix only) |
| err_mask | output | 8 | Bit mask to XOR into that byte (data fix only) |

## Verification
The hardest situation to reach is a correctable verdict, because it needs a stored code that corresponds to data differing from the streamed data in exactly one bit. The bench first computes a reference code from a clean sector image. It then streams a copy with one bit flipped at the first byte, the last byte and an interior position. Separate frames corrupt a single code bit or two data bits. Frames that are abandoned by a second `start`, bytes sent while idle, a byte coincident with `start`, and streams with idle gaps are all checked against the same model.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

   // Verdict codes of the sector check.
   typedef enum logic [1:0] {
      HECC_CLEAN    = 2'd0,
      HECC_DATA_FIX = 2'd1,
      HECC_ECC_FIX  = 2'd2,
      HECC_UNCORR   = 2'd3
   } hecc_status_e;

endpackage

// File: rtl/hecc_byte_parity.sv
// Parity contribution of one byte to the two line-parity halves.
module hecc_byte_parity #(
   parameter int ADDR_BITS = 9,
   parameter int DATA_W    = 8,
   localparam int BIT_BITS = $clog2(DATA_W),
   localparam int HALF_W   = ADDR_BITS + BIT_BITS
) (
   input  logic [ADDR_BITS-1:0] offset,
   input  logic [DATA_W-1:0]    data,
   output logic [HALF_W-1:0]    hi,
   output logic [HALF_W-1:0]    lo
);

   // Select the bit lanes whose in-byte index has bit k equal to val.
   function automatic logic [DATA_W-1:0] lane_sel(input int k, input bit val);
      logic [DATA_W-1:0] m;
      for (int j = 0; j < DATA_W; j++) m[j] = (((j >> k) & 1) == int'(val));
      return m;
   endfunction

   logic odd;
   assign odd = ^data;

   for (genvar k = 0; k < HALF_W; k++) begin : g_bit
      if (k < BIT_BITS) begin : g_lane
         localparam logic [DATA_W-1:0] SEL_H = lane_sel(k, 1'b1);
         localparam logic [DATA_W-1:0] SEL_L = lane_sel(k, 1'b0);
         assign hi[k] = ^(data & SEL_H);
         assign lo[k] = ^(data & SEL_L);
      end else begin : g_line
         assign hi[k] = odd &  offset[k-BIT_BITS];
         assign lo[k] = odd & ~offset[k-BIT_BITS];
      end
   end

endmodule

// File: rtl/hecc_accum.sv
// Frame control and parity accumulation over one sector.
module hecc_accum #(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   localparam int ADDR_BITS   = $clog2(SECTOR_BYTES),
   localparam int HALF_W      = ADDR_BITS + $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              done,
   output logic [HALF_W-1:0] par_hi,
   output logic [HALF_W-1:0] par_lo
);

   localparam logic [ADDR_BITS-1:0] LAST_IDX = ADDR_BITS'(SECTOR_BYTES - 1);

   logic                 busy_q;
   logic [ADDR_BITS-1:0] cnt_q;
   logic [HALF_W-1:0]    c_hi, c_lo;
   logic                 accept;

   hecc_byte_parity #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W)) u_bp (
      .offset (cnt_q),
      .data   (in_data),
      .hi     (c_hi),
      .lo     (c_lo)
   );

   assign accept   = in_valid & busy_q & ~start;
   assign in_ready = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done   <= 1'b0;
         par_hi <= '0;
         par_lo <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            par_hi <= '0;
            par_lo <= '0;
         end else if (accept) begin
            par_hi <= par_hi ^ c_hi;
            par_lo <= par_lo ^ c_lo;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hecc_classify.sv
// Compares stored and fresh codes and registers the verdict.
module hecc_classify
   import nand_hecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   localparam int ADDR_BITS   = $clog2(SECTOR_BYTES),
   localparam int BIT_BITS    = $clog2(DATA_W),
   localparam int HALF_W      = ADDR_BITS + BIT_BITS,
   localparam int ECC_W       = 2 * HALF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eval,
   input  logic [ECC_W-1:0]     stored,
   input  logic [ECC_W-1:0]     fresh,
   output logic                 res_valid,
   output hecc_status_e         status,
   output logic [ADDR_BITS-1:0] fix_byte,
   output logic [DATA_W-1:0]    fix_mask
);

   logic [ECC_W-1:0]     diff;
   logic [HALF_W-1:0]    d_lo, d_hi;
   logic [ADDR_BITS-1:0] loc_byte;
   logic [BIT_BITS-1:0]  loc_bit;
   logic                 in_range;
   logic                 locatable;
   hecc_status_e         verdict;

   assign diff      = stored ^ fresh;
   assign d_lo      = diff[HALF_W-1:0];
   assign d_hi      = diff[ECC_W-1:HALF_W];
   assign loc_byte  = d_hi[HALF_W-1:BIT_BITS];
   assign loc_bit   = d_hi[BIT_BITS-1:0];
   assign locatable = ((d_lo ^ d_hi) == {HALF_W{1'b1}});

   if (SECTOR_BYTES == (1 << ADDR_BITS)) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_part_range
      assign in_range = (32'(loc_byte) < 32'(SECTOR_BYTES));
   end

   always_comb begin
      if (diff == '0)                   verdict = HECC_CLEAN;
      else if (locatable && in_range)   verdict = HECC_DATA_FIX;
      else if (locatable)               verdict = HECC_UNCORR;
      else if ($onehot(diff))           verdict = HECC_ECC_FIX;
      else                              verdict = HECC_UNCORR;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         status    <= HECC_CLEAN;
         fix_byte  <= '0;
         fix_mask  <= '0;
      end else begin
         res_valid <= eval;
         if (eval) begin
            status <= verdict;
            if (verdict == HECC_DATA_FIX) begin
               fix_byte <= loc_byte;
               fix_mask <= DATA_W'(1) << loc_bit;
            end else begin
               fix_byte <= '0;
               fix_mask <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/nand_hecc_engine.sv
// Top: sector Hamming code generator and checker.
module nand_hecc_engine
   import nand_hecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   localparam int ADDR_BITS   = $clog2(SECTOR_BYTES),
   localparam int BIT_BITS    = $clog2(DATA_W),
   localparam int HALF_W      = ADDR_BITS + BIT_BITS,
   localparam int ECC_W       = 2 * HALF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 check_mode,
   input  logic [ECC_W-1:0]     stored_ecc,
   input  logic                 in_valid,
   input  logic [DATA_W-1:0]    in_data,
   output logic                 in_ready,
   output logic                 ecc_valid,
   output logic [ECC_W-1:0]     ecc_code,
   output logic                 result_valid,
   output logic [1:0]           result_status,
   output logic [ADDR_BITS-1:0] err_byte,
   output logic [DATA_W-1:0]    err_mask
);

   if (DATA_W != (1 << BIT_BITS) || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (SECTOR_BYTES < 2) begin : g_bad_sector
      $error("SECTOR_BYTES must be at least 2");
   end

   logic              chk_q;
   logic [ECC_W-1:0]  stored_q;
   logic [HALF_W-1:0] par_hi, par_lo;
   hecc_status_e      status_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_q    <= 1'b0;
         stored_q <= '0;
      end else if (start) begin
         chk_q    <= check_mode;
         stored_q <= stored_ecc;
      end
   end

   hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES), .DATA_W(DATA_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .done     (ecc_valid),
      .par_hi   (par_hi),
      .par_lo   (par_lo)
   );

   // Packed halves, inverted so an erased sector reads back clean.
   assign ecc_code = ~{par_hi, par_lo};

   hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES), .DATA_W(DATA_W)) u_cls (
      .clk       (clk),
      .rst_n     (rst_n),
      .eval      (ecc_valid & chk_q),
      .stored    (stored_q),
      .fresh     (ecc_code),
      .res_valid (result_valid),
      .status    (status_w),
      .fix_byte  (err_byte),
      .fix_mask  (err_mask)
   );

   assign result_status = status_w;

endmodule

// File: rtl/hecc_checker.sv
module hecc_checker #(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   localparam int CNT_W       = $clog2(SECTOR_BYTES) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              in_valid,
   input logic              in_ready,
   input logic              ecc_valid,
   input logic              result_valid,
   input logic [1:0]        result_status,
   input logic [DATA_W-1:0] err_mask
);

   logic [CNT_W-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n || start) seen <= '0;
      else if (in_valid && in_ready && seen != CNT_W'(SECTOR_BYTES)) seen <= seen + 1'b1;
   end

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_valid |=> !ecc_valid);

   a_r4_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_valid |-> (seen == CNT_W'(SECTOR_BYTES)));

   a_r4_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_valid |-> !in_ready);

   a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(ecc_valid));

   a_r9_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_status == 2'd1) |-> $onehot(err_mask));

   a_r11_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_status != 2'd1) |-> (err_mask == '0));

endmodule

bind nand_hecc_engine hecc_checker #(.SECTOR_BYTES(SECTOR_BYTES), .DATA_W(DATA_W)) u_hecc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .ecc_valid     (ecc_valid),
   .result_valid  (result_valid),
   .result_status (result_status),
   .err_mask      (err_mask)
);

// File: tb/tb_nand_hecc_engine.sv
`timescale 1ns/1ps
module tb_nand_hecc_engine;

   typedef logic [7:0] sect_t [512];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        check_mode = 1'b0;
   logic [23:0] stored_ecc = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, ecc_valid, result_valid;
   logic [23:0] ecc_code;
   logic [1:0]  result_status;
   logic [8:0]  err_byte;
   logic [7:0]  err_mask;

   always #2.5 clk = ~clk;

   nand_hecc_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
      .stored_ecc(stored_ecc), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .ecc_valid(ecc_valid), .ecc_code(ecc_code),
      .result_valid(result_valid), .result_status(result_status),
      .err_byte(err_byte), .err_mask(err_mask)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    finished = 1'b0;
   string cur_tag = "R5";

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Behavioural code per R5/R6: positions counted bit by bit.
   function automatic logic [23:0] calc_ecc(input sect_t a);
      logic [11:0] h = '0, l = '0;
      for (int b = 0; b < 512; b++)
         for (int j = 0; j < 8; j++)
            if (a[b][j])
               for (int k = 0; k < 12; k++) begin
                  if ((((b * 8 + j) >> k) & 1) == 1) h[k] = ~h[k];
                  else l[k] = ~l[k];
               end
      return ~{h, l};
   endfunction

   // Reference model, updated on each rising edge from the driven inputs.
   sect_t       cap, tx, clean;
   bit          m_busy = 0, m_done = 0, m_res = 0, m_chk = 0;
   int          m_cnt = 0;
   logic [23:0] m_stored = '0, exp_ecc = '0;
   int          exp_stat = 0, exp_byte = 0, exp_mask = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_res = 0; m_chk = 0; m_cnt = 0;
      end else begin
         m_res  = m_done && m_chk;
         m_done = 0;
         if (start) begin
            m_busy = 1; m_cnt = 0; m_chk = check_mode; m_stored = stored_ecc;
         end else if (in_valid && m_busy) begin
            cap[m_cnt] = in_data;
            m_cnt++;
            if (m_cnt == 512) begin
               logic [23:0] d;
               m_busy  = 0;
               m_done  = 1;
               exp_ecc = calc_ecc(cap);
               d = m_stored ^ exp_ecc;
               exp_byte = 0; exp_mask = 0;
               if (d == 0) exp_stat = 0;
               else if ((((d >> 12) ^ d) & 24'hFFF) == 24'hFFF) begin
                  exp_stat = 1; exp_byte = int'(d >> 15); exp_mask = 1 << d[14:12];
               end else if ($countones(d) == 1) exp_stat = 2;
               else exp_stat = 3;
            end
         end
      end
   end

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R4", {31'b0, in_ready}, {31'b0, m_busy});
         check("R4", {31'b0, ecc_valid}, {31'b0, m_done});
         check("R7", {31'b0, result_valid}, {31'b0, m_res});
         if (m_done) check(cur_tag, {8'b0, ecc_code}, {8'b0, exp_ecc});
         if (m_res) begin
            check(cur_tag, {30'b0, result_status}, exp_stat);
            check(cur_tag, {24'b0, err_mask}, exp_mask);
            if (exp_stat == 1) check(cur_tag, {23'b0, err_byte}, exp_byte);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send_frame(input bit chk, input logic [23:0] st, input int gap, input bit junk);
      start = 1; check_mode = chk; stored_ecc = st; in_valid = junk; in_data = 8'hA5;
      tick();
      start = 0;
      for (int i = 0; i < 512; i++) begin
         if (gap > 0 && (i % gap) == 0) begin in_valid = 0; tick(); end
         in_valid = 1; in_data = tx[i];
         tick();
      end
      in_valid = 0;
      repeat (4) tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", {29'b0, in_ready, ecc_valid, result_valid}, 0);
      rst_n = 1;
      tick();
      check("R1", {29'b0, in_ready, ecc_valid, result_valid}, 0);

      // R6: erased sector produces all-ones code
      cur_tag = "R6";
      for (int i = 0; i < 512; i++) tx[i] = 8'hFF;
      send_frame(0, 0, 0, 0);
      check("R6", {8'b0, exp_ecc}, 32'h00FFFFFF);

      // R5: patterned data, streamed with gaps
      cur_tag = "R5";
      for (int i = 0; i < 512; i++) tx[i] = 8'((i * 37) ^ (i >> 3));
      send_frame(0, 0, 3, 0);
      for (int i = 0; i < 512; i++) tx[i] = (i == 77) ? 8'h10 : 8'h00;
      send_frame(0, 0, 0, 0);

      // R3: bytes while idle are ignored
      cur_tag = "R3";
      in_valid = 1;
      for (int i = 0; i < 10; i++) begin in_data = 8'(i * 29 + 1); tick(); end
      in_valid = 0;
      for (int i = 0; i < 512; i++) tx[i] = 8'(i);
      send_frame(0, 0, 0, 0);

      // R2: byte coincident with start is dropped; mid-frame restart
      cur_tag = "R2";
      for (int i = 0; i < 512; i++) tx[i] = 8'(255 - i);
      send_frame(0, 0, 0, 1);
      start = 1; tick(); start = 0;
      in_valid = 1;
      for (int i = 0; i < 100; i++) begin in_data = 8'h3C; tick(); end
      in_valid = 0;
      send_frame(0, 0, 5, 0);

      // Check-mode frames built from a clean image
      for (int i = 0; i < 512; i++) clean[i] = 8'((i * 13) ^ 8'h5A);

      cur_tag = "R8";
      tx = clean;
      send_frame(1, calc_ecc(clean), 0, 0);

      cur_tag = "R9";
      tx = clean; tx[300] = tx[300] ^ 8'h20;
      send_frame(1, calc_ecc(clean), 2, 0);
      tx = clean; tx[0] = tx[0] ^ 8'h01;
      send_frame(1, calc_ecc(clean), 0, 0);
      tx = clean; tx[511] = tx[511] ^ 8'h80;
      send_frame(1, calc_ecc(clean), 0, 0);

      cur_tag = "R10";
      tx = clean;
      send_frame(1, calc_ecc(clean) ^ 24'h000400, 0, 0);
      send_frame(1, calc_ecc(clean) ^ 24'h800000, 0, 0);

      cur_tag = "R11";
      tx = clean; tx[10] = tx[10] ^ 8'h02; tx[400] = tx[400] ^ 8'h40;
      send_frame(1, calc_ecc(clean), 0, 0);
      tx = clean;
      send_frame(1, calc_ecc(clean) ^ 24'h000003, 0, 0);

      // R7: generate-mode frame after a check frame gives no verdict
      cur_tag = "R7";
      send_frame(0, 24'h123456, 0, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule